// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the status word of an accumulator-style processor and applies to it the flag effects that the rest of the core reports. It keeps eight single-bit flags (carry, zero, interrupt disable, decimal mode, index width, data width, overflow and negative) and a three-bit interrupt priority level. These are eleven stored bits inside a sixteen-bit readable word whose top five bits are always zero.

Each cycle the block can take several kinds of update:
- ALU results for carry, zero, overflow and negative, each with its own enable.
- Bit-mask set and bit-mask clear commands over the low byte.
- Single-flag set and clear commands for carry, interrupt disable and decimal mode.
- An interrupt-accept strobe.
- A full-word restore, used when the word is pulled back from the stack.

The block does not decode instructions. It only applies the effects it is told about, with a fixed priority between them. Each flag is also driven out on its own line, so branch logic can read it directly.

Top module: `status_flags`

## Requirements
- R1: The word read out holds carry at bit 0, zero at bit 1, interrupt disable at bit 2, decimal mode at bit 3, index width at bit 4, data width at bit 5, overflow at bit 6, negative at bit 7 and the priority level at bits 8 to 10. Bits 11 to 15 read 0 at all times. The individual flag outputs equal their bits in the word.
- R2: After reset the word is 0x0004: interrupt disable is 1, decimal mode is 0 and every other bit is 0.
- R3: When its enable is high, each of carry, zero, overflow and negative takes its ALU value on the next clock edge. When its enable is low, the flag holds, whatever the ALU value.
- R4: When decimal mode is 1 and the decimal add/subtract indicator is high, a zero-flag ALU update is discarded and zero keeps its value. With decimal mode at 0, the same update is applied.
- R5: A high bit in the set mask sets the matching bit of the low byte, and a high bit in the clear mask clears it. When both masks select the same bit, the set wins.
- R6: When a mask command and an ALU update target the same flag in the same cycle, the mask command decides the flag.
- R7: The single-flag commands set or clear carry, interrupt disable and decimal mode. Each acts exactly like a one-bit set or clear mask on its flag.
- R8: An interrupt accept leaves interrupt disable at 1 after the edge. This overrides every other update in the same cycle, the restore included.
- R9: A restore loads bits 0 to 10 from the restore word and overrides ALU and mask updates. Restore bits 11 to 15 have no effect on the word.
- R10: The interrupt-enable output is always the inverse of the interrupt disable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_c | input | 1 | ALU carry or borrow, or the bit shifted out |
| alu_z | input | 1 | ALU zero-result indication |
| alu_v | input | 1 | ALU overflow |
| alu_n | input | 1 | ALU negative result |
| upd_c | input | 1 | Apply alu_c to carry |
| upd_z | input | 1 | Apply alu_z to zero |
| upd_v | input | 1 | Apply alu_v to overflow |
| upd_n | input | 1 | Apply alu_n to negative |
| dec_addsub | input | 1 | Current operation is a decimal-capable add or subtract |
| mask_set | input | 8 | Set the selected low-byte bits |
| mask_clr | input | 8 | Clear the selected low-byte bits |
| cmd_sec | input | 1 | Set carry |
| cmd_clc | input | 1 | Clear carry |
| cmd_sei | input | 1 | Set interrupt disable |
| cmd_cli | input | 1 | Clear interrupt disable |
| cmd_sed | input | 1 | Set decimal mode |
| cmd_cld | input | 1 | Clear decimal mode |
| irq_accept | input | 1 | An interrupt request has been accepted |
| restore_en | input | 1 | Load the word from restore_word |
| restore_word | input | 16 | Word to restore |
| status_word | output | 16 | Readable status word |
| flag_c | output | 1 | Carry |
| flag_z | output | 1 | Zero |
| flag_i | output | 1 | Interrupt disable |
| flag_d | output | 1 | Decimal mode |
| flag_x | output | 1 | Index width |
| flag_m | output | 1 | Data width |
| flag_v | output | 1 | Overflow |
| flag_n | output | 1 | Negative |
| ipl | output | 3 | Interrupt priority level |
| irq_enable | output | 1 | Maskable interrupts allowed |

## Verification
The ALU path is driven twice: once with all four enables high and once with the values present but every enable low. This separates capture from hold. The zero update is tried with the decimal indicator high while decimal mode is first on and then off, which shows that only the combination suppresses it. Some steps put a mask, a single-flag command or a restore against an ALU update or an interrupt accept on the same bit, and these expose any wrong ordering of the priorities. Restore words with ones in bits 11 to 15 show whether the unused bits leak into the word.

// File: rtl/sf_pkg.sv
package sf_pkg;
   localparam int unsigned FLAG_COUNT = 8;
   localparam int unsigned POS_C   = 0;
   localparam int unsigned POS_Z   = 1;
   localparam int unsigned POS_I   = 2;
   localparam int unsigned POS_D   = 3;
   localparam int unsigned POS_X   = 4;
   localparam int unsigned POS_M   = 5;
   localparam int unsigned POS_V   = 6;
   localparam int unsigned POS_N   = 7;
   localparam int unsigned POS_IPL = 8;

   // Flags that the arithmetic unit may write directly
   function automatic bit alu_driven(int unsigned pos);
      return (pos == POS_C) || (pos == POS_Z) || (pos == POS_V) || (pos == POS_N);
   endfunction

   typedef enum logic [1:0] {
      SRC_HOLD = 2'd0,
      SRC_ALU  = 2'd1,
      SRC_SET  = 2'd2,
      SRC_CLR  = 2'd3
   } flag_src_e;
endpackage

// File: rtl/sf_flag_bit.sv
module sf_flag_bit
   import sf_pkg::*;
#(
   parameter bit ALU_CAPABLE = 1'b1
) (
   input  logic cur_i,
   input  logic alu_val_i,
   input  logic alu_en_i,
   input  logic set_i,
   input  logic clr_i,
   output logic next_o
);
   flag_src_e src;

   generate
      if (ALU_CAPABLE) begin : g_alu
         always_comb begin
            if (set_i)         src = SRC_SET;
            else if (clr_i)    src = SRC_CLR;
            else if (alu_en_i) src = SRC_ALU;
            else               src = SRC_HOLD;
         end
      end else begin : g_cmd_only
         logic unused_alu;
         assign unused_alu = alu_val_i ^ alu_en_i;
         always_comb begin
            if (set_i)      src = SRC_SET;
            else if (clr_i) src = SRC_CLR;
            else            src = SRC_HOLD;
         end
      end
   endgenerate

   always_comb begin
      unique case (src)
         SRC_SET:  next_o = 1'b1;
         SRC_CLR:  next_o = 1'b0;
         SRC_ALU:  next_o = alu_val_i;
         default:  next_o = cur_i;
      endcase
   end
endmodule

// File: rtl/sf_word_pack.sv
module sf_word_pack #(
   parameter int unsigned W_WORD = 16,
   parameter int unsigned W_REG  = 11
) (
   input  logic [W_REG-1:0]  state_i,
   output logic [W_WORD-1:0] word_o
);
   generate
      if (W_WORD < W_REG) begin : g_bad
         $error("sf_word_pack: word narrower than stored state");
      end else if (W_WORD == W_REG) begin : g_exact
         assign word_o = state_i;
      end else begin : g_pad
         assign word_o = {{(W_WORD-W_REG){1'b0}}, state_i};
      end
   endgenerate
endmodule

// File: rtl/status_flags.sv
module status_flags
   import sf_pkg::*;
#(
   parameter int unsigned W_WORD = 16,
   parameter int unsigned W_IPL  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alu_c,
   input  logic              alu_z,
   input  logic              alu_v,
   input  logic              alu_n,
   input  logic              upd_c,
   input  logic              upd_z,
   input  logic              upd_v,
   input  logic              upd_n,
   input  logic              dec_addsub,
   input  logic [7:0]        mask_set,
   input  logic [7:0]        mask_clr,
   input  logic              cmd_sec,
   input  logic              cmd_clc,
   input  logic              cmd_sei,
   input  logic              cmd_cli,
   input  logic              cmd_sed,
   input  logic              cmd_cld,
   input  logic              irq_accept,
   input  logic              restore_en,
   input  logic [W_WORD-1:0] restore_word,
   output logic [W_WORD-1:0] status_word,
   output logic              flag_c,
   output logic              flag_z,
   output logic              flag_i,
   output logic              flag_d,
   output logic              flag_x,
   output logic              flag_m,
   output logic              flag_v,
   output logic              flag_n,
   output logic [W_IPL-1:0]  ipl,
   output logic              irq_enable
);
   localparam int unsigned W_LOW = FLAG_COUNT;
   localparam int unsigned W_REG = W_LOW + W_IPL;
   localparam logic [W_REG-1:0] RESET_STATE = W_REG'(1) << POS_I;

   if (W_IPL < 1)      begin : g_chk_ipl  $error("status_flags: W_IPL must be at least 1"); end
   if (W_WORD < W_REG) begin : g_chk_word $error("status_flags: W_WORD too small"); end

   logic [W_REG-1:0] state_q, state_d;
   logic [W_LOW-1:0] alu_val, alu_en, set_vec, clr_vec, low_next;
   logic             z_suppress;

   // Zero update is dropped for decimal add/subtract while decimal mode is on
   assign z_suppress = state_q[POS_D] & dec_addsub;

   always_comb begin
      alu_val = '0;
      alu_en  = '0;
      alu_val[POS_C] = alu_c;  alu_en[POS_C] = upd_c;
      alu_val[POS_Z] = alu_z;  alu_en[POS_Z] = upd_z & ~z_suppress;
      alu_val[POS_V] = alu_v;  alu_en[POS_V] = upd_v;
      alu_val[POS_N] = alu_n;  alu_en[POS_N] = upd_n;
   end

   // Single-flag commands fold into the masks
   always_comb begin
      set_vec = mask_set;
      clr_vec = mask_clr;
      set_vec[POS_C] = mask_set[POS_C] | cmd_sec;
      set_vec[POS_I] = mask_set[POS_I] | cmd_sei;
      set_vec[POS_D] = mask_set[POS_D] | cmd_sed;
      clr_vec[POS_C] = mask_clr[POS_C] | cmd_clc;
      clr_vec[POS_I] = mask_clr[POS_I] | cmd_cli;
      clr_vec[POS_D] = mask_clr[POS_D] | cmd_cld;
   end

   genvar gi;
   generate
      for (gi = 0; gi < W_LOW; gi++) begin : g_flag
         sf_flag_bit #(.ALU_CAPABLE(alu_driven(gi))) u_bit (
            .cur_i     (state_q[gi]),
            .alu_val_i (alu_val[gi]),
            .alu_en_i  (alu_en[gi]),
            .set_i     (set_vec[gi]),
            .clr_i     (clr_vec[gi]),
            .next_o    (low_next[gi])
         );
      end
   endgenerate

   always_comb begin
      state_d = {state_q[W_REG-1:W_LOW], low_next};
      if (restore_en) state_d = restore_word[W_REG-1:0];
      if (irq_accept) state_d[POS_I] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= RESET_STATE;
      else        state_q <= state_d;
   end

   sf_word_pack #(.W_WORD(W_WORD), .W_REG(W_REG)) u_pack (
      .state_i (state_q),
      .word_o  (status_word)
   );

   assign flag_c     = state_q[POS_C];
   assign flag_z     = state_q[POS_Z];
   assign flag_i     = state_q[POS_I];
   assign flag_d     = state_q[POS_D];
   assign flag_x     = state_q[POS_X];
   assign flag_m     = state_q[POS_M];
   assign flag_v     = state_q[POS_V];
   assign flag_n     = state_q[POS_N];
   assign ipl        = state_q[POS_IPL +: W_IPL];
   assign irq_enable = ~state_q[POS_I];
endmodule

// File: rtl/status_flags_chk.sv
module status_flags_chk #(
   parameter int unsigned W_WORD = 16,
   parameter int unsigned W_IPL  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_z,
   input logic              dec_addsub,
   input logic [7:0]        mask_set,
   input logic [7:0]        mask_clr,
   input logic              cmd_sei,
   input logic              cmd_cli,
   input logic              irq_accept,
   input logic              restore_en,
   input logic [W_WORD-1:0] restore_word,
   input logic [W_WORD-1:0] status_word,
   input logic              flag_c,
   input logic              flag_z,
   input logic              flag_i,
   input logic              flag_d,
   input logic              irq_enable
);
   localparam int unsigned W_REG = 8 + W_IPL;

   if (W_WORD > W_REG) begin : g_upper
      p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
         status_word[W_WORD-1:W_REG] == '0);
   end

   p_zero_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_z && dec_addsub && flag_d && !mask_set[1] && !mask_clr[1] && !restore_en)
      |=> $stable(flag_z));

   p_set_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_set[0] && !restore_en) |=> flag_c);

   p_cli_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_cli && !cmd_sei && !mask_set[2] && !irq_accept && !restore_en) |=> !flag_i);

   p_irq_forces_i_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_accept |=> flag_i);

   p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_en && !irq_accept) |=> status_word[W_REG-1:0] == $past(restore_word[W_REG-1:0]));

   p_ie_inverse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_enable == !flag_i);
endmodule

bind status_flags status_flags_chk #(.W_WORD(W_WORD), .W_IPL(W_IPL)) u_chk (
   .clk(clk), .rst_n(rst_n), .upd_z(upd_z), .dec_addsub(dec_addsub),
   .mask_set(mask_set), .mask_clr(mask_clr), .cmd_sei(cmd_sei), .cmd_cli(cmd_cli),
   .irq_accept(irq_accept), .restore_en(restore_en), .restore_word(restore_word),
   .status_word(status_word), .flag_c(flag_c), .flag_z(flag_z), .flag_i(flag_i),
   .flag_d(flag_d), .irq_enable(irq_enable)
);

// File: tb/status_flags_test.sv
module status_flags_test;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0, rst_n = 1'b0;
   logic alu_c, alu_z, alu_v, alu_n, upd_c, upd_z, upd_v, upd_n, dec_addsub;
   logic [7:0] mask_set, mask_clr;
   logic cmd_sec, cmd_clc, cmd_sei, cmd_cli, cmd_sed, cmd_cld, irq_accept, restore_en;
   logic [15:0] restore_word, status_word;
   logic flag_c, flag_z, flag_i, flag_d, flag_x, flag_m, flag_v, flag_n, irq_enable;
   logic [2:0] ipl;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [10:0] model;
   logic [15:0] exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   status_flags uut (.*);

   task automatic idle();
      {alu_c, alu_z, alu_v, alu_n, upd_c, upd_z, upd_v, upd_n, dec_addsub} = '0;
      mask_set = '0; mask_clr = '0;
      {cmd_sec, cmd_clc, cmd_sei, cmd_cli, cmd_sed, cmd_cld} = '0;
      irq_accept = 0; restore_en = 0; restore_word = '0;
   endtask

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Driver: inputs already set at a falling edge; predict, clock, queue
   task automatic tick(string tag);
      logic [10:0] n;
      logic [7:0] s, c;
      n = model;
      if (upd_c) n[0] = alu_c;
      if (upd_z && !(model[3] && dec_addsub)) n[1] = alu_z;
      if (upd_v) n[6] = alu_v;
      if (upd_n) n[7] = alu_n;
      s = mask_set | {4'b0, cmd_sed, cmd_sei, 1'b0, cmd_sec};
      c = mask_clr | {4'b0, cmd_cld, cmd_cli, 1'b0, cmd_clc};
      n[7:0] = (n[7:0] & ~c) | s;
      if (restore_en) n = restore_word[10:0];
      if (irq_accept) n[2] = 1'b1;
      model = n;
      @(posedge clk);
      exp_q.push_back({5'b0, n});
      tag_q.push_back(tag);
      @(negedge clk);
      idle();
   endtask

   // Monitor
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         automatic logic [15:0] e = exp_q.pop_front();
         automatic string t = tag_q.pop_front();
         check({t, " word"}, status_word, e);
         check("R1 flag lines", {5'b0, ipl, flag_n, flag_v, flag_m, flag_x, flag_d, flag_i, flag_z, flag_c}, status_word);
         check("R10 irq_enable", {15'b0, irq_enable}, {15'b0, ~e[2]});
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
         $finish;
      end
   end

   initial begin
      idle();
      model = 11'h004;
      repeat (3) @(negedge clk);
      check("R2 reset word", status_word, 16'h0004);
      rst_n = 1;
      @(negedge clk);
      check("R2 after release", status_word, 16'h0004);

      alu_c = 1; alu_z = 1; alu_v = 1; alu_n = 1; upd_c = 1; upd_z = 1; upd_v = 1; upd_n = 1;
      tick("R3 capture all");                                   // 0x00C7
      alu_c = 0; alu_z = 0; alu_v = 0; alu_n = 0;
      tick("R3 enables low hold");
      mask_set = 8'h38;
      tick("R5 mask set D X M");
      alu_z = 0; upd_z = 1; dec_addsub = 1;
      tick("R4 zero held in decimal");
      mask_clr = 8'h08;
      tick("R5 mask clear D");
      alu_z = 0; upd_z = 1; dec_addsub = 1;
      tick("R4 zero updates binary");
      alu_c = 1; upd_c = 1; mask_clr = 8'h01;
      tick("R6 clear beats ALU carry");
      alu_v = 0; upd_v = 1; mask_set = 8'h40; mask_clr = 8'h40;
      tick("R5 set wins over clear and R6");
      cmd_cli = 1;
      tick("R7 cli");
      cmd_sec = 1; cmd_sed = 1;
      tick("R7 sec sed");
      cmd_clc = 1; cmd_cld = 1; alu_c = 1; upd_c = 1;
      tick("R7 clc cld over ALU");
      irq_accept = 1; cmd_cli = 1; mask_clr = 8'h04;
      tick("R8 accept beats clear");
      restore_en = 1; restore_word = 16'hF8A0; mask_set = 8'hFF; alu_c = 1; upd_c = 1;
      tick("R9 restore upper ignored");
      restore_en = 1; restore_word = 16'hFFFF;
      tick("R9 restore all ones");
      cmd_cli = 1;
      tick("R7 cli after restore");
      restore_en = 1; restore_word = 16'h0000; irq_accept = 1;
      tick("R8 accept beats restore");
      mask_clr = 8'hFF;
      tick("R5 clear all low");
      @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule